// File: doc/BRIEF.md
# Register-Programmed Full-Duplex SPI Master

This block is a serial peripheral interface master that software runs through a small 32-bit register port with a single-cycle acknowledge, in the Wishbone style. Software loads up to 128 bits of outgoing data into four data words. It sets a clock divider and a mask of slave-select lines. It then writes a control word with the go bit set. The core drives the serial clock and shifts the frame out on MOSI. At the same time it samples MISO into a 128-bit receive register. The edge that launches data and the edge that samples it are chosen independently, as is the bit order.

Busy is reported through the go bit, which reads back as 1 until the final serial clock edge. The eight active-low select outputs can follow the select register at all times, or they can be asserted only for the length of a transfer. An optional interrupt marks the end of every transfer. The last received bit is always stored no later than the cycle in which completion is signalled.

Top module: `spi_host_regs`

## Requirements
- R1: After reset the select outputs read all ones, the serial clock, MOSI and the interrupt are 0, and every register reads 0.
- R2: A request accepted on a clock edge (cycle, strobe high, acknowledge low) is acknowledged for exactly one cycle after it, with read data valid while acknowledge is high. Word address map: 0 to 3 hold data bits 32k+31..32k (writes load transmit data, reads return receive data), 4 is control, 5 is the divider, 6 is the select mask; divider and mask read back as written.
- R3: A control write with bit 8 (go) at 0 starts nothing: the serial clock stays low and MOSI does not change.
- R4: The serial clock idles low and toggles every divider+1 system clocks during a transfer; its first rising edge comes divider+1 clocks after the edge that accepts the go write.
- R5: Control bits [6:0] give the frame length N, with 0 meaning 128; a transfer produces exactly N rising and N falling serial clock edges.
- R6: With control bit 10 at 0, MOSI takes bit i at rising edge i+1; with bit 10 at 1, MOSI takes bit 0 at the go write and bit i at falling edge i.
- R7: With control bit 9 at 0, MISO is sampled on rising serial clock edges; with bit 9 at 1, on falling edges. The j-th sample is received bit j.
- R8: With control bit 11 at 1, transmitted bit i is data bit i and received bit j is stored at receive bit j; with bit 11 at 0 they are data bit N-1-i and receive bit N-1-j. Receive bits at N and above keep their value.
- R9: Control bit 8 reads 1 from the go write until the final falling edge, then 0. Control writes while busy are ignored.
- R10: Receive data read after busy clears contains every sampled bit, including the one taken on the final edge.
- R11: With control bit 13 at 1, the select outputs equal the inverted mask only while busy and all ones otherwise.
- R12: With control bit 13 at 0, the select outputs equal the inverted mask at all times, also after the transfer.
- R13: With control bit 12 at 1, the interrupt rises in the cycle busy clears and stays high until the next accepted bus access. With bit 12 at 0 it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Write enable |
| bus_adr | input | 3 | Word address |
| bus_wdat | input | 32 | Write data |
| bus_rdat | output | 32 | Read data, valid with acknowledge |
| bus_ack | output | 1 | One-cycle acknowledge |
| irq | output | 1 | Transfer-complete interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 8 | Active-low slave selects |

## Verification
The bench builds the block with its default parameters: eight selects, a 16-bit divider and the 128-bit frame that the 7-bit length field fixes. Because of that, both the full 128-bit frame (length code 0) and the 127-bit frame can be reached. The bench programs divider values from 0 to 2, which keeps long frames short in cycles while still covering the single-clock half period and wider ones. It works through all four pairings of launch and sample edges and both bit orders, so every receive bit position, including the last-edge capture, is observed through the receive words.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  // Control word field positions (the register layout is part of the contract)
  localparam int LEN_W    = 7;
  localparam int GO_BIT   = 8;
  localparam int RXF_BIT  = 9;
  localparam int TXF_BIT  = 10;
  localparam int LSB_BIT  = 11;
  localparam int IE_BIT   = 12;
  localparam int ASEL_BIT = 13;

  localparam int BUS_W   = 32;
  localparam int MAXBITS = 1 << LEN_W;
  localparam int NWORDS  = MAXBITS / BUS_W;
  localparam int ADR_W   = $clog2(NWORDS + 3);
  localparam int CNT_W   = LEN_W + 1;   // holds 1..MAXBITS
  localparam int EDGE_W  = LEN_W + 2;   // holds 0..2*MAXBITS

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             rx_fall;
    logic             tx_fall;
    logic             lsb_first;
  } shift_cfg_t;

  // Length code 0 stands for the full frame
  function automatic logic [CNT_W-1:0] frame_bits(input logic [LEN_W-1:0] len);
    return (len == '0) ? CNT_W'(MAXBITS) : {1'b0, len};
  endfunction

  // Data-register position of serial bit i in an n-bit frame
  function automatic logic [LEN_W-1:0] bit_slot(input logic [CNT_W-1:0] i,
                                                input logic [CNT_W-1:0] n,
                                                input logic lsb_first);
    return LEN_W'(lsb_first ? i : (n - CNT_W'(1) - i));
  endfunction

endpackage

// File: rtl/spi_bus_regs.sv
module spi_bus_regs
  import spi_host_pkg::*;
#(
  parameter int NSEL = 8,
  parameter int DIVW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cyc,
  input  logic               stb,
  input  logic               we,
  input  logic [ADR_W-1:0]   adr,
  input  logic [BUS_W-1:0]   wdat,
  output logic [BUS_W-1:0]   rdat,
  output logic               ack,
  input  logic [MAXBITS-1:0] rx_data,
  input  logic               done,
  output logic [MAXBITS-1:0] tx_data,
  output logic               busy,
  output logic               launch,
  output shift_cfg_t         launch_cfg,
  output logic               auto_sel,
  output logic [DIVW-1:0]    div,
  output logic [NSEL-1:0]    sel,
  output logic               irq
);

  localparam logic [ADR_W-1:0] A_CTRL = ADR_W'(NWORDS);
  localparam logic [ADR_W-1:0] A_DIV  = ADR_W'(NWORDS + 1);
  localparam logic [ADR_W-1:0] A_SEL  = ADR_W'(NWORDS + 2);

  logic             req, wr, ctrl_wr;
  shift_cfg_t       cfg;
  logic             irq_en;
  logic [BUS_W-1:0] rmux;

  assign req     = cyc && stb && !ack;
  assign wr      = req && we;
  assign ctrl_wr = wr && (adr == A_CTRL) && !busy;
  assign launch  = ctrl_wr && wdat[GO_BIT];

  assign launch_cfg.len       = wdat[LEN_W-1:0];
  assign launch_cfg.rx_fall   = wdat[RXF_BIT];
  assign launch_cfg.tx_fall   = wdat[TXF_BIT];
  assign launch_cfg.lsb_first = wdat[LSB_BIT];

  // Transmit words, one register per bus word
  generate
    for (genvar w = 0; w < NWORDS; w++) begin : g_txw
      always_ff @(posedge clk) begin
        if (rst)
          tx_data[w*BUS_W +: BUS_W] <= '0;
        else if (wr && adr == ADR_W'(w))
          tx_data[w*BUS_W +: BUS_W] <= wdat;
      end
    end
  endgenerate

  always_comb begin
    rmux = '0;
    for (int w = 0; w < NWORDS; w++)
      if (adr == ADR_W'(w)) rmux = rx_data[w*BUS_W +: BUS_W];
    if (adr == A_CTRL)
      rmux = {{(BUS_W-14){1'b0}}, auto_sel, irq_en, cfg.lsb_first,
              cfg.tx_fall, cfg.rx_fall, busy, 1'b0, cfg.len};
    if (adr == A_DIV) rmux = BUS_W'(div);
    if (adr == A_SEL) rmux = BUS_W'(sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack      <= 1'b0;
      rdat     <= '0;
      cfg      <= '0;
      irq_en   <= 1'b0;
      auto_sel <= 1'b0;
      busy     <= 1'b0;
      div      <= '0;
      sel      <= '0;
      irq      <= 1'b0;
    end else begin
      ack <= req;
      if (req) rdat <= rmux;
      if (ctrl_wr) begin
        cfg      <= launch_cfg;
        irq_en   <= wdat[IE_BIT];
        auto_sel <= wdat[ASEL_BIT];
      end
      if (launch)     busy <= 1'b1;
      else if (done)  busy <= 1'b0;
      if (wr && adr == A_DIV) div <= wdat[DIVW-1:0];
      if (wr && adr == A_SEL) sel <= wdat[NSEL-1:0];
      if (done && irq_en) irq <= 1'b1;
      else if (req)       irq <= 1'b0;
    end
  end

  // R2: acknowledge is a single-cycle pulse
  a_r2_ack_pulse: assert property (@(posedge clk) disable iff (rst) ack |=> !ack);
  // R9: configuration is frozen while a transfer runs
  a_r9_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(cfg) && $stable(irq_en) && $stable(auto_sel)));
  // R13: interrupt only rises as busy falls
  a_r13_irq_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $fell(busy));

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            launch,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            sclk,
  output logic            tick,
  output logic            tick_rise
);

  logic [DIVW-1:0] cnt;

  assign tick      = run && (cnt == '0);
  assign tick_rise = tick && !sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (launch) begin
      cnt  <= div;
      sclk <= 1'b0;
    end else if (run) begin
      if (cnt == '0) begin
        cnt  <= div;
        sclk <= !sclk;
      end else begin
        cnt <= cnt - DIVW'(1);
      end
    end
  end

  // R4: serial clock rests low whenever no transfer is running
  a_r4_idle_low: assert property (@(posedge clk) disable iff (rst) !run |-> !sclk);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_host_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  shift_cfg_t         launch_cfg,
  input  logic [MAXBITS-1:0] tx_data,
  input  logic               miso,
  input  logic               tick,
  input  logic               tick_rise,
  output logic               mosi,
  output logic [MAXBITS-1:0] rx_data,
  output logic               done
);

  logic              rx_fall, tx_fall, lsb_first;
  logic [CNT_W-1:0]  nbits, n_launch;
  logic [EDGE_W-1:0] ecnt, e_next;
  logic [CNT_W-1:0]  cur_idx, next_idx;
  logic              sample_now;

  assign n_launch   = frame_bits(launch_cfg.len);
  assign e_next     = ecnt + EDGE_W'(1);
  assign cur_idx    = ecnt[EDGE_W-1:1];          // bit of the current clock period
  assign next_idx   = cur_idx + CNT_W'(1);       // bit launched on a falling edge
  assign sample_now = tick_rise ^ rx_fall;
  assign done       = tick && (e_next == {nbits, 1'b0});

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_fall   <= 1'b0;
      tx_fall   <= 1'b0;
      lsb_first <= 1'b0;
      nbits     <= '0;
      ecnt      <= '0;
      mosi      <= 1'b0;
      rx_data   <= '0;
    end else if (launch) begin
      rx_fall   <= launch_cfg.rx_fall;
      tx_fall   <= launch_cfg.tx_fall;
      lsb_first <= launch_cfg.lsb_first;
      nbits     <= n_launch;
      ecnt      <= '0;
      if (launch_cfg.tx_fall)
        mosi <= tx_data[bit_slot('0, n_launch, launch_cfg.lsb_first)];
    end else if (tick) begin
      ecnt <= e_next;
      if (tick_rise && !tx_fall)
        mosi <= tx_data[bit_slot(cur_idx, nbits, lsb_first)];
      if (!tick_rise && tx_fall && next_idx < nbits)
        mosi <= tx_data[bit_slot(next_idx, nbits, lsb_first)];
      if (sample_now)
        rx_data[bit_slot(cur_idx, nbits, lsb_first)] <= miso;
    end
  end

  // R4: rising edges fall on even edge counts, falling on odd
  a_r4_edge_parity: assert property (@(posedge clk) disable iff (rst)
    tick |-> (tick_rise == !ecnt[0]));
  // R5: edge counter never passes twice the frame length
  a_r5_edge_bound: assert property (@(posedge clk) disable iff (rst)
    ecnt <= {nbits, 1'b0});
  // R10: completion comes on a falling edge, with the last sample stored in that cycle
  a_r10_done_on_fall: assert property (@(posedge clk) disable iff (rst)
    done |-> !tick_rise);

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int NSEL = 8,
  parameter int DIVW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_cyc,
  input  logic             bus_stb,
  input  logic             bus_we,
  input  logic [ADR_W-1:0] bus_adr,
  input  logic [BUS_W-1:0] bus_wdat,
  output logic [BUS_W-1:0] bus_rdat,
  output logic             bus_ack,
  output logic             irq,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic [NSEL-1:0]  ss_n
);

  logic [MAXBITS-1:0] tx_data, rx_data;
  logic               busy, launch, done, auto_sel;
  logic               tick, tick_rise;
  shift_cfg_t         launch_cfg;
  logic [DIVW-1:0]    div;
  logic [NSEL-1:0]    sel;

  spi_bus_regs #(.NSEL(NSEL), .DIVW(DIVW)) u_regs (
    .clk(clk), .rst(rst), .cyc(bus_cyc), .stb(bus_stb), .we(bus_we),
    .adr(bus_adr), .wdat(bus_wdat), .rdat(bus_rdat), .ack(bus_ack),
    .rx_data(rx_data), .done(done), .tx_data(tx_data), .busy(busy),
    .launch(launch), .launch_cfg(launch_cfg), .auto_sel(auto_sel),
    .div(div), .sel(sel), .irq(irq)
  );

  spi_sclk_gen #(.DIVW(DIVW)) u_clk (
    .clk(clk), .rst(rst), .launch(launch), .run(busy), .div(div),
    .sclk(sclk), .tick(tick), .tick_rise(tick_rise)
  );

  spi_shift_engine u_shift (
    .clk(clk), .rst(rst), .launch(launch), .launch_cfg(launch_cfg),
    .tx_data(tx_data), .miso(miso), .tick(tick), .tick_rise(tick_rise),
    .mosi(mosi), .rx_data(rx_data), .done(done)
  );

  assign ss_n = (auto_sel && !busy) ? {NSEL{1'b1}} : ~sel;

  // R3: MOSI only moves at a launch or during a transfer
  a_r3_mosi_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy && !launch) |=> $stable(mosi));
  // R11: automatic selects release in the cycle the transfer ends
  a_r11_auto_release: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && auto_sel) |-> (&ss_n));

endmodule

// File: tb/sim_spi_host_regs.sv
`timescale 1ns/1ps
module sim_spi_host_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_adr = '0;
  logic [31:0] bus_wdat = '0;
  logic [31:0] bus_rdat;
  logic        bus_ack, irq, sclk, mosi;
  logic        miso = 1'b0;
  logic [7:0]  ss_n;

  always #10 clk = ~clk;   // 50 MHz

  spi_host_regs u0 (
    .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_rdat(bus_rdat), .bus_ack(bus_ack),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  logic [127:0] m_tx, m_rx;
  logic [31:0]  m_rdat;
  int   m_div, m_ss, m_cnt, m_edges, m_n, m_len;
  bit   m_busy, m_sclk, m_mosi, m_irq, m_ack;
  bit   m_txf, m_rxf, m_lsb, m_ie, m_ass;

  function automatic int ord(input int i);
    return m_lsb ? i : (m_n - 1 - i);
  endfunction

  always @(posedge clk) begin
    bit req, fin, was_busy;
    int bi;
    if (rst) begin
      m_tx = '0; m_rx = '0; m_rdat = '0; m_div = 0; m_ss = 0; m_cnt = 0;
      m_edges = 0; m_n = 0; m_len = 0; m_busy = 0; m_sclk = 0; m_mosi = 0;
      m_irq = 0; m_ack = 0; m_txf = 0; m_rxf = 0; m_lsb = 0; m_ie = 0; m_ass = 0;
    end else begin
      req = bus_cyc && bus_stb && !m_ack;
      fin = 0;
      was_busy = m_busy;
      if (req) begin
        case (bus_adr)
          3'd0, 3'd1, 3'd2, 3'd3: m_rdat = m_rx[bus_adr*32 +: 32];
          3'd4: m_rdat = (m_ass << 13) | (m_ie << 12) | (m_lsb << 11) | (m_txf << 10)
                       | (m_rxf << 9) | (m_busy << 8) | m_len;
          3'd5: m_rdat = m_div;
          3'd6: m_rdat = m_ss;
          default: m_rdat = 0;
        endcase
      end
      if (m_busy) begin
        if (m_cnt == 0) begin
          m_edges++;
          if (!m_sclk) begin
            bi = (m_edges - 1) / 2;
            if (!m_txf) m_mosi = m_tx[ord(bi)];
            if (!m_rxf) m_rx[ord(bi)] = miso;
          end else begin
            bi = m_edges / 2;
            if (m_txf && bi < m_n) m_mosi = m_tx[ord(bi)];
            if (m_rxf) m_rx[ord(bi - 1)] = miso;
          end
          m_sclk = !m_sclk;
          m_cnt = m_div;
          if (m_edges == 2 * m_n) begin m_busy = 0; fin = 1; end
        end else m_cnt--;
      end
      if (req && bus_we) begin
        case (bus_adr)
          3'd0, 3'd1, 3'd2, 3'd3: m_tx[bus_adr*32 +: 32] = bus_wdat;
          3'd4: if (!was_busy) begin
            m_len = bus_wdat[6:0]; m_rxf = bus_wdat[9]; m_txf = bus_wdat[10];
            m_lsb = bus_wdat[11]; m_ie = bus_wdat[12]; m_ass = bus_wdat[13];
            if (bus_wdat[8]) begin
              m_busy = 1; m_n = (m_len == 0) ? 128 : m_len;
              m_edges = 0; m_cnt = m_div; m_sclk = 0;
              if (m_txf) m_mosi = m_tx[ord(0)];
            end
          end
          3'd5: m_div = bus_wdat[15:0];
          3'd6: m_ss = bus_wdat[7:0];
          default: ;
        endcase
      end
      if (req) m_irq = 0;
      if (fin && m_ie) m_irq = 1;
      m_ack = req;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(sclk === m_sclk, "R4 sclk", sclk, m_sclk);
      chk(mosi === m_mosi, "R6 mosi", mosi, m_mosi);
      chk(irq === m_irq, "R13 irq", irq, m_irq);
      chk(bus_ack === m_ack, "R2 ack", bus_ack, m_ack);
      if (m_ack) chk(bus_rdat === m_rdat, "R2 rdat", bus_rdat, m_rdat);
      chk(ss_n === ((m_ass && !m_busy) ? 8'hFF : ~m_ss[7:0]), "R11 ss_n", ss_n,
          (m_ass && !m_busy) ? 8'hFF : ~m_ss[7:0]);
    end
  end

  // ---------------- serial slave and edge monitor ----------------
  logic [127:0] slv_pat = '0;
  bit   s_txf = 0, s_rxf = 0, prev_sclk = 0;
  int   k = 0, rises = 0;
  logic got[$];

  always @(negedge clk) begin
    if (sclk !== prev_sclk) begin
      if (sclk) rises++;
      if (sclk != s_rxf) k++;
      if (sclk == s_txf) got.push_back(mosi);
    end
    prev_sclk = sclk;
    miso = (k < 128) ? slv_pat[k] : 1'b0;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog expired");
      wrap_up();
    end
  end

  // ---------------- stimulus ----------------
  logic [127:0] tb_tx = '0, exp_rx = '0;
  logic [7:0]   tb_sel = '0;

  task automatic bus(input bit w, input logic [2:0] a, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = w; bus_adr = a; bus_wdat = d;
    do @(negedge clk); while (!bus_ack);
    q = bus_rdat;
    bus_cyc = 0; bus_stb = 0; bus_we = 0;
  endtask

  task automatic run_xfer(input logic [6:0] len, input bit txf, rxf, lsb, ie, ass,
                          input logic [127:0] pat, input bit poke);
    logic [31:0] q;
    int n, bad;
    n = (len == 0) ? 128 : len;
    s_txf = txf; s_rxf = rxf; slv_pat = pat; k = 0; rises = 0; got.delete();
    bus(1, 3'd4, {18'b0, ass, ie, lsb, txf, rxf, 1'b1, 1'b0, len}, q);
    chk(ss_n === ~tb_sel, "R11/R12 select during transfer", ss_n, ~tb_sel);
    if (poke) begin
      bus(1, 3'd4, 32'h0000_0107, q);
      bus(0, 3'd4, 0, q);
      chk(q[8] == 1'b1 && q[6:0] == len && q[13] == ass, "R9 busy flag and locked ctrl",
          q, {18'b0, ass, ie, lsb, txf, rxf, 1'b1, 1'b0, len});
    end
    while (m_busy) @(negedge clk);
    @(negedge clk);
    chk(irq === ie, "R13 interrupt at end", irq, ie);
    chk(ss_n === (ass ? 8'hFF : ~tb_sel), "R11/R12 select after transfer", ss_n,
        ass ? 8'hFF : ~tb_sel);
    chk(rises == n, "R5 rising edge count", rises, n);
    bad = (got.size() == n) ? 0 : 1;
    for (int i = 0; i < n && i < got.size(); i++)
      if (got[i] !== tb_tx[lsb ? i : n - 1 - i]) bad++;
    chk(bad == 0, "R6/R8 MOSI bit stream", bad, 0);
    for (int j = 0; j < n; j++) exp_rx[lsb ? j : n - 1 - j] = pat[j];
    bus(0, 3'd4, 0, q);
    chk(q[8] == 1'b0, "R9 busy cleared", q[8], 0);
    chk(irq === 1'b0, "R13 interrupt cleared by access", irq, 0);
    for (int w = 0; w < 4; w++) begin
      bus(0, 3'(w), 0, q);
      chk(q === exp_rx[w*32 +: 32], "R7/R8/R10 receive word", q, exp_rx[w*32 +: 32]);
    end
  endtask

  task automatic put_tx(input int w, input logic [31:0] d);
    logic [31:0] q;
    bus(1, 3'(w), d, q);
    tb_tx[w*32 +: 32] = d;
  endtask

  initial begin
    logic [31:0] q;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ss_n === 8'hFF, "R1 selects idle", ss_n, 8'hFF);
    chk(sclk === 1'b0 && mosi === 1'b0 && irq === 1'b0, "R1 outputs low", {sclk, mosi, irq}, 0);
    bus(0, 3'd4, 0, q); chk(q === 0, "R1 ctrl reset", q, 0);
    bus(0, 3'd0, 0, q); chk(q === 0, "R1 receive reset", q, 0);

    bus(1, 3'd5, 32'd1, q); bus(1, 3'd6, 32'h01, q); tb_sel = 8'h01;
    bus(0, 3'd5, 0, q); chk(q === 32'd1, "R2 divider readback", q, 1);
    bus(0, 3'd6, 0, q); chk(q === 32'h01, "R2 select readback", q, 1);
    put_tx(0, 32'h9E37_79B9); put_tx(1, 32'h0F1E_2D3C);
    put_tx(2, 32'hC001_D00D); put_tx(3, 32'h8421_7BDE);

    // go bit low: nothing happens
    rises = 0;
    bus(1, 3'd4, 32'h0000_3A04, q);
    repeat (30) @(negedge clk);
    chk(rises == 0 && sclk === 1'b0, "R3 no clock without go", rises, 0);
    bus(0, 3'd4, 0, q);
    chk(q[8] == 1'b0 && q[6:0] == 7'd4, "R3 ctrl stored, not busy", q, 32'h3A04);

    run_xfer(7'd4, 0, 1, 1, 1, 1, 128'h0000_0000_0000_0000_0000_0000_0000_000B, 0);
    bus(1, 3'd5, 32'd0, q);
    run_xfer(7'd0, 1, 0, 0, 0, 0, 128'h5A5A_C3C3_0FF0_1234_8765_4321_DEAD_0001, 0);
    bus(1, 3'd5, 32'd2, q); bus(1, 3'd6, 32'h24, q); tb_sel = 8'h24;
    run_xfer(7'd127, 0, 0, 1, 1, 1, 128'h7FFF_0001_AAAA_5555_1357_9BDF_2468_ACE0, 0);
    bus(1, 3'd5, 32'd1, q);
    run_xfer(7'd5, 1, 1, 0, 0, 1, 128'h0000_0000_0000_0000_0000_0000_0000_0016, 1);
    run_xfer(7'd9, 0, 1, 0, 1, 0, 128'h0000_0000_0000_0000_0000_0000_0000_01A3, 0);

    repeat (5) @(negedge clk);
    wrap_up();
  end

endmodule